// File: doc/BRIEF.md
# Serial EEPROM Byte Command Controller

This block is the master side of a four-wire SPI link to a 512-location, 8-bit serial EEPROM. A host hands it one request at a time: enable writes, disable writes, write one byte, or read one byte. Each request carries a 9-bit address and an 8-bit data value. The controller turns the request into instruction, address and data bytes and shifts them out on the link. It controls chip select, and it produces the serial clock from the system clock through a divider.

The device address is 9 bits wide, but only 8 of them travel in the address byte. The top bit is carried inside the instruction byte. Every write is followed automatically by a status-poll loop, and the host sees completion only once the device reports ready. A read returns its byte on the response pins, together with a one-cycle done pulse.

The request side uses a valid/ready handshake. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the host must hold its request until it is taken. While an operation is in progress, the host is held off by `req_ready` being low, and any `req_valid` on those cycles is ignored. The response is a plain pulse and cannot be back-pressured.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` then stays low until the response pulse. Any `req_valid` while `req_ready` is low causes no frame and does not change the result.
- R3: `req_op` encodes the operation as follows: 0 is write-enable, 1 is write-disable, 2 is byte write, 3 is byte read. Write-enable sends the single byte 0x06 in its own chip-select frame. Write-disable sends the single byte 0x04 in its own chip-select frame.
- R4: A byte write sends a single frame of three bytes: (0x02 OR address bit 8 shifted to bit 3), then address bits 7..0, then the data byte.
- R5: After every write frame, the controller sends frames of two bytes, 0x05 followed by a dummy 0x00. It keeps sending them while bit 0 of the second returned byte is 1. The response pulse follows the first poll frame that returns bit 0 equal to 0.
- R6: A byte read sends a single frame of three bytes: (0x03 OR address bit 8 at bit 3), then address bits 7..0, then a dummy 0x00. The byte received during the third slot is presented on `rsp_rdata` with the response pulse.
- R7: The link runs with the clock idle low. MOSI changes on the rising SCK edge, and both sides sample on the falling edge. Bytes are sent MSB first, eight SCK cycles per byte. `sck` is low whenever `cs_n` is high.
- R8: One SCK period is 2×`SCK_HALF` system clocks.
- R9: Between any two frames, and after the last frame of an operation before the response pulse, `cs_n` stays high for at least 2×`SCK_HALF` clocks.
- R10: `rsp_valid` lasts exactly one cycle per accepted request and occurs only while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_op | input | 2 | Operation code (see R3) |
| req_addr | input | 9 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read (valid with `rsp_valid` on reads) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
Most faults inside the sequencer show up at the link within one frame. A wrong byte index or a wrong value in the opcode table makes the byte list of a frame differ. Corrupted address packing moves the ninth bit out of bit 3 of the first byte. A broken poll decision shows up when an operation completes: the number of status frames is wrong, or the response pulse arrives before the device reports ready. A divider or shifter fault shows up within a single byte, as a wrong SCK period or as bits swapped in the received byte.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  typedef enum logic [1:0] {
    OP_WREN  = 2'd0,
    OP_WRDI  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } ee_op_e;

  localparam logic [7:0] INS_WREN  = 8'h06;
  localparam logic [7:0] INS_WRDI  = 8'h04;
  localparam logic [7:0] INS_WRITE = 8'h02;
  localparam logic [7:0] INS_READ  = 8'h03;
  localparam logic [7:0] INS_RDSR  = 8'h05;
  localparam logic [7:0] DUMMY     = 8'h00;
  localparam int         HIBIT_POS = 3;

  typedef enum logic [1:0] {
    S_IDLE, S_LOAD, S_WAIT, S_GAP
  } seq_state_e;
endpackage

// File: rtl/spi_ee_shifter.sv
module spi_ee_shifter #(
  parameter int SCK_HALF = 2,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx,
  output logic              done,
  output logic [BYTE_W-1:0] rx,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  logic              active;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          cnt    <= '0;
          bitn   <= '0;
          sh     <= tx;
        end
      end else if (cnt == CW'(SCK_HALF - 1)) begin
        cnt <= '0;
        if (!sck) begin
          sck  <= 1'b1;
          mosi <= sh[BYTE_W-1];
        end else begin
          sck  <= 1'b0;
          sh   <= {sh[BYTE_W-2:0], miso};
          bitn <= bitn + 1'b1;
          if (bitn == BW'(BYTE_W - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign rx = sh;
endmodule

// File: rtl/spi_ee_seq.sv
module spi_ee_seq
  import spi_ee_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int ADDR_W   = 9,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              cs_n,
  output logic              eng_start,
  output logic [BYTE_W-1:0] eng_tx,
  input  logic              eng_done,
  input  logic [BYTE_W-1:0] eng_rx
);
  localparam int GAP = 2 * SCK_HALF;
  localparam int GW  = $clog2(GAP) + 1;

  seq_state_e        state;
  ee_op_e            op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic [1:0]        idx;
  logic [1:0]        last_idx;
  logic              polling;
  logic [BYTE_W-1:0] last_rx;
  logic [GW-1:0]     gcnt;
  logic [BYTE_W-1:0] ins_hi;
  logic              more_poll;

  assign ins_hi    = BYTE_W'(addr_q[ADDR_W-1]) << HIBIT_POS;
  assign req_ready = (state == S_IDLE);
  assign eng_start = (state == S_LOAD);
  assign more_poll = (op_q == OP_WRITE) && (!polling || last_rx[0]);

  always_comb begin
    if (polling)                                    last_idx = 2'd1;
    else if (op_q == OP_WREN || op_q == OP_WRDI)    last_idx = 2'd0;
    else                                            last_idx = 2'd2;
  end

  always_comb begin
    eng_tx = DUMMY;
    if (polling) begin
      eng_tx = (idx == 2'd0) ? INS_RDSR : DUMMY;
    end else begin
      case (idx)
        2'd0: begin
          case (op_q)
            OP_WREN:  eng_tx = INS_WREN;
            OP_WRDI:  eng_tx = INS_WRDI;
            OP_WRITE: eng_tx = INS_WRITE | ins_hi;
            default:  eng_tx = INS_READ | ins_hi;
          endcase
        end
        2'd1:    eng_tx = addr_q[BYTE_W-1:0];
        default: eng_tx = (op_q == OP_WRITE) ? data_q : DUMMY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= OP_WREN;
      addr_q    <= '0;
      data_q    <= '0;
      idx       <= '0;
      polling   <= 1'b0;
      last_rx   <= '0;
      gcnt      <= '0;
      cs_n      <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q    <= ee_op_e'(req_op);
            addr_q  <= req_addr;
            data_q  <= req_wdata;
            idx     <= '0;
            polling <= 1'b0;
            cs_n    <= 1'b0;
            state   <= S_LOAD;
          end
        end
        S_LOAD: state <= S_WAIT;
        S_WAIT: begin
          if (eng_done) begin
            if (idx == last_idx) begin
              cs_n    <= 1'b1;
              last_rx <= eng_rx;
              gcnt    <= '0;
              state   <= S_GAP;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_LOAD;
            end
          end
        end
        default: begin
          if (gcnt == GW'(GAP - 1)) begin
            if (more_poll) begin
              polling <= 1'b1;
              idx     <= '0;
              cs_n    <= 1'b0;
              state   <= S_LOAD;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= (op_q == OP_READ) ? last_rx : '0;
              state     <= S_IDLE;
            end
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl #(
  parameter int SCK_HALF = 2,
  parameter int ADDR_W   = 9,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  logic              eng_start;
  logic              eng_done;
  logic [BYTE_W-1:0] eng_tx;
  logic [BYTE_W-1:0] eng_rx;

  spi_ee_seq #(.SCK_HALF(SCK_HALF), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .cs_n      (cs_n),
    .eng_start (eng_start),
    .eng_tx    (eng_tx),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx)
  );

  spi_ee_shifter #(.SCK_HALF(SCK_HALF), .BYTE_W(BYTE_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_start),
    .tx    (eng_tx),
    .done  (eng_done),
    .rx    (eng_rx),
    .sck   (sck),
    .mosi  (mosi),
    .miso  (miso)
  );
endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic sck,
  input logic mosi,
  input logic cs_n
);
  // R7: the clock stays low outside a frame
  p_sck_low_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R7: data out holds while SCK is high, through the sampling edge
  p_mosi_hold_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R2: an idle controller never has the device selected
  p_ready_only_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

  // R10: the response is a single-cycle pulse
  p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10: the response comes with the device deselected
  p_rsp_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cs_n);

  // R9: a deselect lasts more than one cycle
  p_cs_gap_min_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .sck       (sck),
  .mosi      (mosi),
  .cs_n      (cs_n)
);

// File: tb/spi_eeprom_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_eeprom_ctrl_tb_top;
  localparam int HALF       = 3;
  localparam int BUSY_POLLS = 2;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = '0;
  logic [8:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       sck, mosi, cs_n;
  logic       miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit pending = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_eeprom_ctrl #(.SCK_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural device model
  logic [7:0]  mem [512];
  bit          dev_wel = 0;
  int          busy_left = 0;
  bit          in_frame = 0;
  int          bitc = 0, nb = 0;
  logic [7:0]  cur, outb;
  logic [7:0]  fb [4];
  logic [31:0] frames [$];
  int          last_rise = 0;
  int          last_sck = 0;

  initial for (int i = 0; i < 512; i++) mem[i] = 8'(i) ^ 8'hA5;

  function automatic logic [7:0] resp_byte(input int n);
    if (n == 2 && (fb[0] & 8'hF7) == 8'h03) return mem[{fb[0][3], fb[1]}];
    if (n == 1 && fb[0] == 8'h05) return {7'b0, busy_left != 0};
    return 8'h00;
  endfunction

  always @(negedge cs_n) if (rst_n) begin
    chk(cyc - last_rise >= 2 * HALF, "R9 deselect gap", cyc - last_rise, 2 * HALF);
    in_frame = 1; bitc = 0; nb = 0; fb[0] = 0; fb[1] = 0; fb[2] = 0; fb[3] = 0;
  end

  always @(posedge sck) if (in_frame) begin
    if (bitc == 0) outb = resp_byte(nb);
    else chk(cyc - last_sck == 2 * HALF, "R8 sck period", cyc - last_sck, 2 * HALF);
    last_sck = cyc;
    miso = outb[7 - bitc];
  end

  always @(negedge sck) if (in_frame) begin
    cur = {cur[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      if (nb < 4) fb[nb] = cur;
      nb++;
      bitc = 0;
    end
  end

  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0;
    last_rise = cyc;
    miso = 1'b0;
    chk(bitc == 0, "R7 whole bytes per frame", bitc, 0);
    frames.push_back({8'(nb), fb[0], fb[1], fb[2]});
    if (nb == 1 && fb[0] == 8'h06) dev_wel = 1;
    if (nb == 1 && fb[0] == 8'h04) dev_wel = 0;
    if (nb == 3 && (fb[0] & 8'hF7) == 8'h02 && dev_wel) begin
      mem[{fb[0][3], fb[1]}] = fb[2];
      busy_left = BUSY_POLLS;
    end
    if (nb == 2 && fb[0] == 8'h05 && busy_left > 0) busy_left--;
  end

  // per-clock reference checks
  always @(negedge clk) if (rst_n) begin
    chk(!(cs_n === 1'b1 && sck !== 1'b0), "R7 sck idle low when deselected", sck, 0);
    chk(!(rsp_valid && !pending), "R10 unexpected response", rsp_valid, 0);
    if (rsp_valid) pending = 0;
  end

  task automatic do_op(input int op, input int addr, input int data,
                       input int exp_rd, input bit poke, input string tag);
    logic [31:0] exp [$];
    int polls, t;
    bit got;
    polls = (op == 2) ? ((dev_wel) ? BUSY_POLLS + 1 : 1) : 0;
    case (op)
      0: exp.push_back({8'd1, 8'h06, 16'h0});
      1: exp.push_back({8'd1, 8'h04, 16'h0});
      2: exp.push_back({8'd3, 8'h02 | (8'(addr >> 8) << 3), 8'(addr), 8'(data)});
      default: exp.push_back({8'd3, 8'h03 | (8'(addr >> 8) << 3), 8'(addr), 8'h00});
    endcase
    for (int i = 0; i < polls; i++) exp.push_back({8'd2, 8'h05, 16'h0});
    frames.delete();
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_addr = 9'(addr); req_wdata = 8'(data);
    pending = 1;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, {"R2 ready drops after accept ", tag}, req_ready, 0);
    if (poke) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_op = 2'd1; req_addr = 9'h1FF; req_wdata = 8'h00;
      @(negedge clk);
      req_valid = 0;
    end
    got = 0; t = 0;
    while (!got && t < 30000) begin
      if (rsp_valid) got = 1; else begin @(negedge clk); t++; end
    end
    chk(got, {"R10 response seen ", tag}, got, 1);
    if (op == 3) chk(rsp_rdata == 8'(exp_rd), {"R6 read data ", tag}, rsp_rdata, exp_rd);
    repeat (4 * HALF + 20) @(negedge clk);
    chk(frames.size() == exp.size(), {"R2 R5 frame count ", tag}, frames.size(), exp.size());
    for (int i = 0; i < exp.size() && i < frames.size(); i++)
      chk(frames[i] == exp[i], {"R3 R4 R5 R6 frame bytes ", tag}, frames[i], exp[i]);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0, "R1 link idle in reset", {cs_n, sck}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n === 1'b1, "R1 cs_n after reset", cs_n, 1);
    chk(sck === 1'b0, "R1 sck after reset", sck, 0);
    chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid === 1'b0, "R1 no response after reset", rsp_valid, 0);
    do_op(2, 9'h123, 8'h96, 0, 0, "R5 write while disabled");
    do_op(0, 0, 0, 0, 0, "R3 wren");
    do_op(2, 9'h123, 8'h96, 0, 1, "R4 R2 write high half busy-poke");
    do_op(2, 9'h045, 8'h5A, 0, 0, "R4 write low half");
    do_op(1, 0, 0, 0, 0, "R3 wrdi");
    do_op(2, 9'h045, 8'hFF, 0, 0, "R5 write after disable");
    do_op(3, 9'h123, 0, 8'h96, 0, "R6 read high half");
    do_op(3, 9'h045, 0, 8'h5A, 1, "R6 R2 read low half busy-poke");
    do_op(3, 9'h1FF, 0, 8'hFF ^ 8'hA5, 0, "R6 read top");
    do_op(3, 9'h100, 0, 8'h00 ^ 8'hA5, 0, "R6 read bit8 only");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles max", WATCHDOG, WATCHDOG);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule